// File: doc/BRIEF.md
# Rename Stage Stall and Skid Controller

This block is the control state machine of a superscalar rename stage. Each cycle decode may present a group of up to `WIDTH` instruction slots. For every slot the block sees a squashed flag and a count of destination registers. From these, and from the space reported by the reorder buffer, the issue queue and the physical register free pool, it decides which slots go downstream this cycle. It also tells decode when to hold off and steers an external skid buffer that parks groups the stage could not finish. The map lookups and writes are done elsewhere. This block only issues per-slot accept and skip strobes and the push, pop and flush controls of the skid buffer.

The reported queue counts arrive over a feedback path that is `FB_DELAY` cycles old. Each count is therefore reduced by `WIDTH * FB_DELAY` before use, and the smaller of the two reduced values caps the slots accepted in one cycle. A group may be renamed only in part. The slot at which work stopped is kept in a resume index, and renaming continues from that slot of the oldest skid group. The block keeps a copy of each parked group's slot count, squashed flags and destination counts, up to `SKID_GROUPS` groups.

The five states, with their encodings on `fsm_state`, are Idle (0), Running (1), Blocked (2), Unblocking (3) and Squashing (4). The named transitions are:
- start (Idle to Running)
- block (Idle, Running or Unblocking to Blocked)
- release (Blocked to Unblocking)
- direct release (Blocked to Running)
- drain done (Unblocking to Running)
- squash (any state to Squashing)
- recover (Squashing to Running)

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset `fsm_state` is Idle (0). `stall_decode`, `acc_mask`, `skip_mask` and `resume_idx` are all zero.
- R2: Usable space is computed separately for the reorder buffer and for the issue queue, each as its reported count minus `WIDTH*FB_DELAY`. The limit is the smaller of the two. In Idle, Running or Unblocking, when work is present and the limit is zero or negative, no slot is accepted, any incoming decode group is pushed, and the state becomes Blocked.
- R3: Slots are walked from low to high index. A live (non-squashed) slot is accepted only while fewer live slots than the limit have been accepted this cycle. Reaching the limit at a live slot stops the walk and moves to Blocked.
- R4: A slot whose squashed flag is set shows in `skip_mask`, never in `acc_mask`, and does not count against the limit or the register pool.
- R5: A live slot whose destination count exceeds the physical registers still unclaimed this cycle stops the walk at that slot, and the state becomes Blocked. Each accepted slot claims its destination count.
- R6: `stall_decode` is high exactly in Blocked and Unblocking. In Blocked, no slot is accepted and every non-empty decode group is pushed into the skid buffer.
- R7: Blocked leaves only when no downstream stall is present, both usable counts are positive and at least one free register exists. It goes to Running if the skid buffer is empty and no group arrives, and to Unblocking otherwise.
- R8: In Unblocking, `from_skid` is high and the walk uses the oldest skid group starting at `resume_idx`. A fully finished front group is popped. When the buffer becomes empty the state returns to Running.
- R9: A squash or reorder-buffer-squash input in any state asserts `skid_flush`, clears `resume_idx`, accepts nothing and enters Squashing. It takes priority over every other transition.
- R10: Squashing persists while either squash input is high. It moves to Running on the first cycle with both low, and ignores decode in that cycle.
- R11: `resume_idx` becomes 0 after a group is walked to its end. It takes the stopping slot when the walk stops partway, and is unchanged while Blocked.
- R12: A downstream stall (execute or commit) in Idle, Running or Unblocking accepts nothing, pushes any incoming decode group and moves to Blocked.
- R13: Idle moves to Running on the first cycle a decode group is walked without blocking, and stays Idle while no group arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_cnt | input | CW | Number of valid slots in the decode group (0 = none) |
| dec_squashed | input | WIDTH | Per-slot squashed flags of the decode group |
| dec_dst | input | WIDTH*DST_W | Per-slot destination register counts, slot i at bits [i*DST_W +: DST_W] |
| exe_stall | input | 1 | Stall request from the execute stage |
| cmt_stall | input | 1 | Stall request from commit |
| rob_free | input | CNT_W | Reported free reorder-buffer entries |
| iq_free | input | CNT_W | Reported free issue-queue entries |
| preg_free | input | CNT_W | Free physical registers |
| cmt_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| acc_mask | output | WIDTH | Slots sent downstream this cycle (positions in the source group) |
| skip_mask | output | WIDTH | Squashed slots skipped this cycle |
| from_skid | output | 1 | Source group is the oldest skid group, not decode |
| stall_decode | output | 1 | Hold request to decode |
| skid_push | output | 1 | Append the decode group to the skid buffer |
| skid_pop | output | 1 | Remove the oldest skid group |
| skid_flush | output | 1 | Empty the skid buffer |
| resume_idx | output | IDX_W | Slot at which the oldest skid group resumes |
| fsm_state | output | 3 | Current state code |

## Verification
The walk is exercised with groups of four live slots, with alternating squashed slots, with a limit of two (to tell a partial stop from a clean finish), and with a limit of two where the squashed slots would exceed the limit if they were counted. Register pressure is tried with destination counts of 1, 2, 1 against a pool of two, which separates the register stop from the space stop and also exercises the resume from a middle slot. Blocking is driven by zero and negative limits, by each downstream stall, and by a group arriving while already stalled. This last case fills two skid groups and checks that draining them takes two Unblocking cycles. Squashes are raised from Blocked, from Unblocking and together with a stall, followed by a long randomized run checked against a behavioural model every cycle.

// File: rtl/rename_ctl_pkg.sv
package rename_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCK   = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } rn_state_e;

endpackage

// File: rtl/rename_space_calc.sv
module rename_space_calc #(
    parameter int WIDTH    = 4,
    parameter int FB_DELAY = 1,
    parameter int CNT_W    = 8,
    parameter int CW       = $clog2(WIDTH + 1)
) (
    input  logic [CNT_W-1:0] rob_free,
    input  logic [CNT_W-1:0] iq_free,
    output logic             rob_ok,
    output logic             iq_ok,
    output logic             lim_pos,
    output logic [CW-1:0]    lim_cap
);
    localparam int RESERVE = WIDTH * FB_DELAY;
    localparam int SW      = CNT_W + 2;

    logic signed [SW-1:0] rob_use;
    logic signed [SW-1:0] iq_use;
    logic signed [SW-1:0] lim_s;

    // Counts are reduced by what may still be in flight on the feedback path.
    assign rob_use = $signed({2'b00, rob_free}) - SW'(RESERVE);
    assign iq_use  = $signed({2'b00, iq_free})  - SW'(RESERVE);
    assign lim_s   = (rob_use < iq_use) ? rob_use : iq_use;

    assign rob_ok  = !rob_use[SW-1] && (rob_use != '0);
    assign iq_ok   = !iq_use[SW-1]  && (iq_use  != '0);
    assign lim_pos = !lim_s[SW-1]   && (lim_s   != '0);

    always_comb begin
        if (!lim_pos) begin
            lim_cap = '0;
        end else if (lim_s[SW-2:0] >= (SW-1)'(WIDTH)) begin
            lim_cap = CW'(WIDTH);
        end else begin
            lim_cap = lim_s[CW-1:0];
        end
    end

endmodule

// File: rtl/rename_slot_walk.sv
module rename_slot_walk #(
    parameter int WIDTH = 4,
    parameter int DST_W = 2,
    parameter int CNT_W = 8,
    parameter int CW    = $clog2(WIDTH + 1),
    parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [IDX_W-1:0]       start_idx,
    input  logic [CW-1:0]          grp_cnt,
    input  logic [WIDTH-1:0]       sq_flags,
    input  logic [WIDTH*DST_W-1:0] dst_flat,
    input  logic [CW-1:0]          lim_cap,
    input  logic [CNT_W-1:0]       preg_free,
    output logic [WIDTH-1:0]       acc_mask,
    output logic [WIDTH-1:0]       skip_mask,
    output logic                   stopped,
    output logic [IDX_W-1:0]       stop_idx
);
    logic [CNT_W-1:0] regs_left;
    logic [CW-1:0]    taken;
    logic [CNT_W-1:0] need;

    // Ordered walk: squashed slots are free, live slots claim limit and registers.
    always_comb begin
        acc_mask  = '0;
        skip_mask = '0;
        stopped   = 1'b0;
        stop_idx  = '0;
        regs_left = preg_free;
        taken     = '0;
        need      = '0;
        for (int i = 0; i < WIDTH; i++) begin
            need = CNT_W'(dst_flat[i*DST_W +: DST_W]);
            if (!stopped && (i >= int'(start_idx)) && (i < int'(grp_cnt))) begin
                if (sq_flags[i]) begin
                    skip_mask[i] = 1'b1;
                end else if ((taken == lim_cap) || (regs_left < need)) begin
                    stopped  = 1'b1;
                    stop_idx = IDX_W'(i);
                end else begin
                    acc_mask[i] = 1'b1;
                    taken       = taken + CW'(1);
                    regs_left   = regs_left - need;
                end
            end
        end
    end

endmodule

// File: rtl/rename_skid_meta.sv
module rename_skid_meta #(
    parameter int WIDTH  = 4,
    parameter int DST_W  = 2,
    parameter int CW     = $clog2(WIDTH + 1),
    parameter int DEPTH  = 2,
    parameter int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int LW     = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic                   pop,
    input  logic                   flush,
    input  logic [CW-1:0]          in_cnt,
    input  logic [WIDTH-1:0]       in_sq,
    input  logic [WIDTH*DST_W-1:0] in_dst,
    output logic [CW-1:0]          fr_cnt,
    output logic [WIDTH-1:0]       fr_sq,
    output logic [WIDTH*DST_W-1:0] fr_dst,
    output logic                   empty,
    output logic                   full,
    output logic [LW-1:0]          level
);
    logic [CW-1:0]          cnt_mem [DEPTH];
    logic [WIDTH-1:0]       sq_mem  [DEPTH];
    logic [WIDTH*DST_W-1:0] dst_mem [DEPTH];
    logic [PW-1:0]          wr_ptr;
    logic [PW-1:0]          rd_ptr;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({push, pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            cnt_mem[wr_ptr] <= in_cnt;
            sq_mem[wr_ptr]  <= in_sq;
            dst_mem[wr_ptr] <= in_dst;
        end
    end

    assign fr_cnt = cnt_mem[rd_ptr];
    assign fr_sq  = sq_mem[rd_ptr];
    assign fr_dst = dst_mem[rd_ptr];
    assign empty  = (level == '0);
    assign full   = (level == LW'(DEPTH));

    // R6: a group parked while the buffer is full would be lost
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> !full);

    // R8: a pop always removes a stored group
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);

    // R9: flush leaves the buffer empty
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
    import rename_ctl_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int FB_DELAY    = 1,
    parameter int CNT_W       = 8,
    parameter int DST_W       = 2,
    parameter int SKID_GROUPS = 2,
    parameter int CW          = $clog2(WIDTH + 1),
    parameter int IDX_W       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          dec_cnt,
    input  logic [WIDTH-1:0]       dec_squashed,
    input  logic [WIDTH*DST_W-1:0] dec_dst,
    input  logic                   exe_stall,
    input  logic                   cmt_stall,
    input  logic [CNT_W-1:0]       rob_free,
    input  logic [CNT_W-1:0]       iq_free,
    input  logic [CNT_W-1:0]       preg_free,
    input  logic                   cmt_squash,
    input  logic                   rob_squashing,
    output logic [WIDTH-1:0]       acc_mask,
    output logic [WIDTH-1:0]       skip_mask,
    output logic                   from_skid,
    output logic                   stall_decode,
    output logic                   skid_push,
    output logic                   skid_pop,
    output logic                   skid_flush,
    output logic [IDX_W-1:0]       resume_idx,
    output logic [2:0]             fsm_state
);
    localparam int LW = $clog2(SKID_GROUPS + 1);

    rn_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    logic sq_any, dec_has, any_stall, preg_any;
    logic rob_ok, iq_ok, lim_pos;
    logic [CW-1:0] lim_cap;

    logic [CW-1:0]          fr_cnt;
    logic [WIDTH-1:0]       fr_sq;
    logic [WIDTH*DST_W-1:0] fr_dst;
    logic                   sk_empty, sk_full;
    logic [LW-1:0]          sk_level;

    logic [IDX_W-1:0]       w_start;
    logic [CW-1:0]          w_cnt;
    logic [WIDTH-1:0]       w_sq;
    logic [WIDTH*DST_W-1:0] w_dst;
    logic [WIDTH-1:0]       w_acc, w_skip;
    logic                   w_stopped;
    logic [IDX_W-1:0]       w_stop_idx;

    assign sq_any    = cmt_squash | rob_squashing;
    assign dec_has   = (dec_cnt != '0);
    assign any_stall = exe_stall | cmt_stall;
    assign preg_any  = (preg_free != '0);
    assign from_skid = (state_q == ST_UNBLOCK);

    rename_space_calc #(
        .WIDTH(WIDTH), .FB_DELAY(FB_DELAY), .CNT_W(CNT_W), .CW(CW)
    ) u_space (
        .rob_free(rob_free), .iq_free(iq_free),
        .rob_ok(rob_ok), .iq_ok(iq_ok), .lim_pos(lim_pos), .lim_cap(lim_cap)
    );

    rename_skid_meta #(
        .WIDTH(WIDTH), .DST_W(DST_W), .CW(CW), .DEPTH(SKID_GROUPS), .LW(LW)
    ) u_skid (
        .clk(clk), .rst_n(rst_n),
        .push(skid_push), .pop(skid_pop), .flush(skid_flush),
        .in_cnt(dec_cnt), .in_sq(dec_squashed), .in_dst(dec_dst),
        .fr_cnt(fr_cnt), .fr_sq(fr_sq), .fr_dst(fr_dst),
        .empty(sk_empty), .full(sk_full), .level(sk_level)
    );

    // Source group: oldest parked group while unblocking, decode otherwise.
    assign w_start = from_skid ? idx_q  : '0;
    assign w_cnt   = from_skid ? fr_cnt : dec_cnt;
    assign w_sq    = from_skid ? fr_sq  : dec_squashed;
    assign w_dst   = from_skid ? fr_dst : dec_dst;

    rename_slot_walk #(
        .WIDTH(WIDTH), .DST_W(DST_W), .CNT_W(CNT_W), .CW(CW), .IDX_W(IDX_W)
    ) u_walk (
        .start_idx(w_start), .grp_cnt(w_cnt), .sq_flags(w_sq), .dst_flat(w_dst),
        .lim_cap(lim_cap), .preg_free(preg_free),
        .acc_mask(w_acc), .skip_mask(w_skip),
        .stopped(w_stopped), .stop_idx(w_stop_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        acc_mask   = '0;
        skip_mask  = '0;
        skid_push  = 1'b0;
        skid_pop   = 1'b0;
        skid_flush = sq_any;
        if (sq_any) begin
            state_d = ST_SQUASH;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_SQUASH: begin
                    state_d = ST_RUN;
                end
                ST_BLOCK: begin
                    skid_push = dec_has;
                    if (!any_stall && rob_ok && iq_ok && preg_any) begin
                        state_d = (sk_empty && !dec_has) ? ST_RUN : ST_UNBLOCK;
                    end
                end
                ST_IDLE, ST_RUN, ST_UNBLOCK: begin
                    if (any_stall) begin
                        state_d   = ST_BLOCK;
                        skid_push = dec_has;
                    end else if (!from_skid && !dec_has) begin
                        state_d = state_q;
                    end else if (!lim_pos) begin
                        state_d   = ST_BLOCK;
                        skid_push = dec_has;
                    end else begin
                        acc_mask  = w_acc;
                        skip_mask = w_skip;
                        if (w_stopped) begin
                            state_d   = ST_BLOCK;
                            idx_d     = w_stop_idx;
                            skid_push = dec_has;
                        end else begin
                            idx_d = '0;
                            if (from_skid) begin
                                skid_pop  = 1'b1;
                                skid_push = dec_has;
                                state_d   = (sk_level == LW'(1) && !dec_has) ? ST_RUN : ST_UNBLOCK;
                            end else begin
                                state_d = ST_RUN;
                            end
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign stall_decode = (state_q == ST_BLOCK) || (state_q == ST_UNBLOCK);
    assign resume_idx   = idx_q;
    assign fsm_state    = state_q;

    // R9: squash wins over every other transition
    p_squash_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sq_any |=> (state_q == ST_SQUASH) && (idx_q == '0));

    // R6: nothing goes downstream while blocked
    p_blocked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK) |-> (acc_mask == '0));

    // R8: unblocking always has a parked group to work on
    p_unblock_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNBLOCK) |-> !sk_empty);

    // R11: running never carries a partial resume point
    p_run_idx_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (idx_q == '0));

    // R11: resume point holds while blocked
    p_hold_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && !sq_any) |=> $stable(idx_q));

    // R2: acceptance needs positive usable space
    p_accept_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mask != '0) |-> lim_pos);

    // R4: a slot is never both accepted and skipped
    p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mask & skip_mask) == '0);

    // R3: accepted live slots never exceed the limit
    p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(acc_mask) <= int'(lim_cap));

endmodule

// File: tb/test_rename_flow_ctrl.sv
`timescale 1ns/1ps
module test_rename_flow_ctrl;
    localparam int WIDTH = 4;
    localparam int RES   = 4;   // WIDTH * FB_DELAY

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] d_cnt;
    logic [3:0] d_sq;
    logic [7:0] d_dst;
    logic exe, cmt, c_sq, c_rsq;
    logic [7:0] rob, iq, preg;

    logic [3:0] acc_mask, skip_mask;
    logic from_skid, stall_decode, skid_push, skid_pop, skid_flush;
    logic [1:0] resume_idx;
    logic [2:0] fsm_state;

    rename_flow_ctrl i_rename_flow_ctrl (
        .clk(clk), .rst_n(rst_n),
        .dec_cnt(d_cnt), .dec_squashed(d_sq), .dec_dst(d_dst),
        .exe_stall(exe), .cmt_stall(cmt),
        .rob_free(rob), .iq_free(iq), .preg_free(preg),
        .cmt_squash(c_sq), .rob_squashing(c_rsq),
        .acc_mask(acc_mask), .skip_mask(skip_mask), .from_skid(from_skid),
        .stall_decode(stall_decode), .skid_push(skid_push), .skid_pop(skid_pop),
        .skid_flush(skid_flush), .resume_idx(resume_idx), .fsm_state(fsm_state)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int         cnt;
        logic [3:0] sq;
        logic [7:0] dst;
    } grp_t;
    grp_t q[$];

    int m_state, m_idx, n_state, n_idx;
    logic [3:0] e_acc, e_skip;
    bit e_push, e_pop, e_flush;

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d at %0t", what, got, exp, $time);
        end
    endtask

    task automatic idle_in();
        d_cnt = 0; d_sq = 0; d_dst = 8'h55;
        exe = 0; cmt = 0; c_sq = 0; c_rsq = 0;
        rob = 20; iq = 20; preg = 50;
    endtask

    task automatic grp(input int c, input logic [3:0] s, input logic [7:0] d);
        d_cnt = 3'(c); d_sq = s; d_dst = d;
    endtask

    // Behavioural reference of one cycle
    task automatic model_eval();
        int urob, uiq, lim, start, cnt, taken, left, need;
        logic [3:0] sqv;
        logic [7:0] dv;
        bit sq, dhas, stop;
        e_acc = 0; e_skip = 0; e_push = 0; e_pop = 0;
        n_state = m_state; n_idx = m_idx;
        sq = c_sq || c_rsq;
        dhas = (d_cnt != 0);
        urob = int'(rob) - RES;
        uiq  = int'(iq) - RES;
        lim  = (urob < uiq) ? urob : uiq;
        e_flush = sq;
        if (sq) begin
            n_state = 4; n_idx = 0;
        end else if (m_state == 4) begin
            n_state = 1;
        end else if (m_state == 2) begin
            e_push = dhas;
            if (!exe && !cmt && urob > 0 && uiq > 0 && preg > 0)
                n_state = (q.size() == 0 && !dhas) ? 1 : 3;
        end else begin
            if (exe || cmt) begin
                n_state = 2; e_push = dhas;
            end else if (m_state != 3 && !dhas) begin
                n_state = m_state;
            end else if (lim <= 0) begin
                n_state = 2; e_push = dhas;
            end else begin
                if (m_state == 3) begin
                    cnt = q[0].cnt; sqv = q[0].sq; dv = q[0].dst; start = m_idx;
                end else begin
                    cnt = int'(d_cnt); sqv = d_sq; dv = d_dst; start = 0;
                end
                taken = 0; left = int'(preg); stop = 0;
                for (int i = start; i < cnt && !stop; i++) begin
                    need = int'(dv[i*2 +: 2]);
                    if (sqv[i]) e_skip[i] = 1'b1;
                    else if (taken >= lim || left < need) begin stop = 1; n_idx = i; end
                    else begin e_acc[i] = 1'b1; taken++; left -= need; end
                end
                if (stop) begin
                    n_state = 2; e_push = dhas;
                end else begin
                    n_idx = 0;
                    if (m_state == 3) begin
                        e_pop = 1; e_push = dhas;
                        n_state = (q.size() == 1 && !dhas) ? 1 : 3;
                    end else begin
                        n_state = 1;
                    end
                end
            end
        end
    endtask

    task automatic tick();
        grp_t g;
        #1;
        model_eval();
        chk("R3 R4 R5 acc_mask", int'(acc_mask), int'(e_acc));
        chk("R4 skip_mask", int'(skip_mask), int'(e_skip));
        chk("R6 R8 stall_decode", int'(stall_decode), (m_state == 2 || m_state == 3) ? 1 : 0);
        chk("R8 from_skid", int'(from_skid), (m_state == 3) ? 1 : 0);
        chk("R6 R12 skid_push", int'(skid_push), int'(e_push));
        chk("R8 skid_pop", int'(skid_pop), int'(e_pop));
        chk("R9 skid_flush", int'(skid_flush), int'(e_flush));
        chk("R11 resume_idx", int'(resume_idx), m_idx);
        chk("R2 R7 R10 R13 fsm_state", int'(fsm_state), m_state);
        @(posedge clk);
        if (e_flush) q.delete();
        else begin
            if (e_pop) void'(q.pop_front());
            if (e_push) begin
                g.cnt = int'(d_cnt); g.sq = d_sq; g.dst = d_dst;
                q.push_back(g);
            end
        end
        m_state = n_state; m_idx = n_idx;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        idle_in();
        m_state = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 state after reset", int'(fsm_state), 0);
        chk("R1 stall after reset", int'(stall_decode), 0);
        chk("R1 acc after reset", int'(acc_mask), 0);
        chk("R1 skip after reset", int'(skip_mask), 0);
        chk("R1 idx after reset", int'(resume_idx), 0);
        @(negedge clk);

        // R13: idle holds with no group, then starts on a full group
        idle_in(); tick();
        grp(4, 4'b0000, 8'h55); tick();
        chk("R13 running after first group", int'(fsm_state), 1);

        // R4: alternating squashed slots
        grp(4, 4'b0101, 8'h55); tick();

        // R4: squashed slots free under a limit of two (rob 6 -> 2)
        rob = 6; grp(4, 4'b0101, 8'h55); tick();
        chk("R4 no block when squashed skip", int'(fsm_state), 1);

        // R3 + R11: partial group, resume at slot 2
        grp(4, 4'b0000, 8'h55); tick();
        chk("R11 idx kept at 2", int'(resume_idx), 2);
        idle_in(); tick();          // blocked -> unblocking (R7)
        tick();                     // drain front from slot 2 (R8)
        chk("R8 back to running", int'(fsm_state), 1);
        tick();

        // R2: limit exactly zero and negative
        iq = 4; grp(3, 4'b0000, 8'h15); tick();
        chk("R2 blocked at zero limit", int'(fsm_state), 2);
        d_cnt = 0; iq = 3; tick();  // R7: stays blocked
        iq = 20; tick();            // release
        tick();                     // drain
        tick();

        // R5: register shortage at slot 1
        preg = 2; grp(3, 4'b0000, 8'b00_01_10_01); tick();
        chk("R5 stop at slot 1", int'(resume_idx), 1);
        d_cnt = 0; preg = 0; tick(); // R7 held
        preg = 10; tick();
        tick(); tick();

        // R12 + R6: downstream stall, then a group arriving while stalled
        exe = 1; grp(2, 4'b0000, 8'h05); tick();
        grp(4, 4'b0010, 8'h55); tick();
        d_cnt = 0; tick();
        exe = 0; tick();            // unblocking with two parked groups
        tick(); tick();
        chk("R8 drained two groups", int'(fsm_state), 1);
        tick();

        // R7: stall with no group releases straight to running
        cmt = 1; tick();
        cmt = 0; tick(); tick();

        // R9 + R10: squash while blocked with parked data
        exe = 1; grp(4, 4'b0000, 8'h55); tick();
        exe = 0; d_cnt = 0; c_sq = 1; tick();
        c_sq = 0; c_rsq = 1; grp(4, 4'b0000, 8'h55); tick();
        chk("R10 holds squashing", int'(fsm_state), 4);
        c_rsq = 0; tick();
        chk("R10 recovered", int'(fsm_state), 1);
        d_cnt = 0; tick();

        // R9: squash together with a stall, and squash during unblocking
        rob = 5; grp(4, 4'b0000, 8'h55); tick();
        rob = 20; d_cnt = 0; tick();
        c_sq = 1; exe = 1; tick();
        c_sq = 0; exe = 0; tick(); tick();

        // Randomized phase
        for (int n = 0; n < 4000; n++) begin
            idle_in();
            rob  = 8'($urandom_range(0, 12));
            iq   = 8'($urandom_range(2, 14));
            preg = 8'($urandom_range(0, 9));
            exe  = ($urandom_range(0, 99) < 8);
            cmt  = ($urandom_range(0, 99) < 5);
            c_sq = ($urandom_range(0, 99) < 3);
            c_rsq = ($urandom_range(0, 99) < 3);
            if (!stall_decode)
                grp($urandom_range(0, 4), 4'($urandom), 8'($urandom));
            tick();
        end

        summary();
        $finish;
    end

endmodule